// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is a parameterised general-purpose I/O port, 32 bits wide by default. It is programmed through a simple single-cycle register bus. It samples pad inputs, drives pad outputs and their enables bit by bit, and can pass auxiliary signals straight to chosen output bits. It also raises a level interrupt when selected edges appear on input bits. Software works on eight word registers: sampled input, output data, output enable, interrupt enable, trigger polarity, auxiliary select, control and interrupt status.

The port changes state only at a "sampling step". A bus write goes into a staging copy of the register and is seen at the following step, not at once. In the default mode a step occurs on every system clock cycle. When the control register selects external timing, a step occurs only on the chosen edge of a separate clock input. That input is synchronised and its edges are found in the system clock domain, so all state stays on one clock. Pad inputs also pass through two-flop synchronisers before they are sampled.

The control register holds four bits that other logic decodes: bit 0 is the global interrupt enable, bit 1 is the interrupt flag, bit 2 selects external timing, and bit 3 selects the falling edge of the external clock. Registers sit at byte offsets 0x00 (input), 0x04 (output), 0x08 (output enable), 0x0C (interrupt enable), 0x10 (trigger polarity), 0x14 (auxiliary select), 0x18 (control) and 0x1C (interrupt status).

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and `pad_out` and `pad_oe` are all zero.
- R2: Each writable register reads back the last value written once a step has passed. A read at an offset that is not word aligned, or at 0x20 or above, returns zero.
- R3: A read of offset 0x00 returns (sampled pads AND NOT output-enable) OR output register. Writes to offset 0x00 have no effect.
- R4: At each step, the output register keeps only the bits whose output-enable bit is 1. `pad_oe` equals the output-enable register, and `pad_out` is never 1 where `pad_oe` is 0.
- R5: At each step, an output bit whose auxiliary-select bit is 1 takes the value of `aux_in` for that bit. The other bits keep the written output value.
- R6: A bus write does not change the register's readable value or the pads until the next sampling step.
- R7: With control bit 2 at 0, a sampling step occurs on every system clock cycle.
- R8: With control bit 2 at 1 and bit 3 at 0, steps occur only on rising edges of `ext_clk`. Falling edges cause no step.
- R9: With control bits 2 and 3 both at 1, steps occur only on falling edges of `ext_clk`. Rising edges cause no step.
- R10: An input bit makes an event when it rises and its polarity bit is 1, or when it falls and its polarity bit is 0. Edges of the other direction make no event.
- R11: An event is recorded only when control bit 0 is 1 and the bit's interrupt-enable bit is 1.
- R12: Recorded events are ORed into the status register, where they stay until software overwrites them. Each recorded event also sets control bit 1. `irq` is high exactly while control bit 1 is set, and writing zero to status and control clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the current registers |
| pad_in | input | DATA_W (32) | Pad inputs, asynchronous |
| pad_out | output | DATA_W (32) | Pad output values |
| pad_oe | output | DATA_W (32) | Pad output enables |
| aux_in | input | DATA_W (32) | Auxiliary output sources, synchronous to `clk` |
| ext_clk | input | 1 | External sampling clock, asynchronous |
| irq | output | 1 | Interrupt request, high while the interrupt flag is set |

## Verification
The assertion that steps are never back to back in external mode relies on `ext_clk` holding each level for at least two system cycles, so that the synchroniser passes on every level. The bench holds each level for five cycles. The sticky-status and masking assertions assume `aux_in` is synchronous to `clk` and that each bus access lasts one cycle. The bench drives every input at the falling edge and keeps each pad value steady for at least four cycles, so each change reaches a step before the next one.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int REG_COUNT = 8;

  typedef enum logic [2:0] {
    RIDX_IN    = 3'd0,
    RIDX_OUT   = 3'd1,
    RIDX_OE    = 3'd2,
    RIDX_INTE  = 3'd3,
    RIDX_PTRIG = 3'd4,
    RIDX_AUX   = 3'd5,
    RIDX_CTRL  = 3'd6,
    RIDX_INTS  = 3'd7
  } reg_idx_e;

  localparam int CTL_GIE   = 0;
  localparam int CTL_IFLAG = 1;
  localparam int CTL_XCLK  = 2;
  localparam int CTL_XNEG  = 3;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_step_gen.sv
module gpio_step_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic xclk_sync,
  input  logic xclk_mode,
  input  logic xclk_neg,
  output logic step
);
  logic prev_q;
  logic xedge;

  always_comb begin
    xedge = (xclk_sync != prev_q) && (xclk_sync != xclk_neg);
    step  = xclk_mode ? xedge : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= xclk_sync;
  end

  // R8
  no_back_to_back_xstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && xclk_mode) |=> !(step && xclk_mode));
endmodule

// File: rtl/gpio_event_logic.sv
module gpio_event_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] old_in,
  input  logic [W-1:0] new_in,
  input  logic [W-1:0] ptrig,
  input  logic [W-1:0] inte,
  input  logic         gie,
  output logic [W-1:0] hits,
  output logic         any_hit
);
  logic [W-1:0] rose, fell, relevant;

  always_comb begin
    rose     = new_in & ~old_in;
    fell     = old_in & ~new_in;
    relevant = (ptrig & rose) | (~ptrig & fell);
    hits     = gie ? (relevant & inte) : '0;
    any_hit  = |hits;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  input  logic [DATA_W-1:0] aux_in,
  input  logic              ext_clk,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  // input synchronisers
  logic [DATA_W-1:0] pad_sync;
  logic              xclk_sync;
  gpio_sync2 #(.W(DATA_W)) u_pad_sync (.clk(clk), .rst_n(rst_core_n), .d(pad_in), .q(pad_sync));
  gpio_sync2 #(.W(1))      u_xclk_sync (.clk(clk), .rst_n(rst_core_n), .d(ext_clk), .q(xclk_sync));

  // staged (written) and current (applied) registers
  logic [DATA_W-1:0] nx_out, nx_oe, nx_inte, nx_ptrig, nx_aux, nx_ctrl, nx_ints;
  logic [DATA_W-1:0] nx_out_d, nx_oe_d, nx_inte_d, nx_ptrig_d, nx_aux_d, nx_ctrl_d, nx_ints_d;
  logic [DATA_W-1:0] cr_in, cr_out, cr_oe, cr_inte, cr_ptrig, cr_aux, cr_ctrl, cr_ints;

  // bus decode
  logic [WORD_W-1:0]    word_idx;
  logic                 mapped;
  logic [REG_COUNT-1:0] wr_hit;
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign mapped   = (bus_addr[1:0] == 2'b00) && (word_idx < WORD_W'(REG_COUNT));

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_wdec
    assign wr_hit[g] = bus_sel && bus_we && mapped && (word_idx == WORD_W'(g));
  end

  // sampling step
  logic step;
  gpio_step_gen u_step (
    .clk(clk), .rst_n(rst_core_n), .xclk_sync(xclk_sync),
    .xclk_mode(cr_ctrl[CTL_XCLK]), .xclk_neg(cr_ctrl[CTL_XNEG]), .step(step)
  );

  logic [DATA_W-1:0] step_in, step_out, step_ints, step_ctrl, flag_vec, hits;
  logic              any_hit;

  gpio_event_logic #(.W(DATA_W)) u_evt (
    .old_in(cr_in), .new_in(step_in), .ptrig(nx_ptrig), .inte(nx_inte),
    .gie(nx_ctrl[CTL_GIE]), .hits(hits), .any_hit(any_hit)
  );

  always_comb begin
    step_in   = pad_sync & ~nx_oe;
    step_out  = ((nx_out & ~nx_aux) | (aux_in & nx_aux)) & nx_oe;
    flag_vec  = '0;
    flag_vec[CTL_IFLAG] = any_hit;
    step_ints = nx_ints | hits;
    step_ctrl = nx_ctrl | flag_vec;
  end

  // staged next-state: a bus write wins over the step's own update
  always_comb begin
    nx_out_d   = step ? step_out  : nx_out;
    nx_ctrl_d  = step ? step_ctrl : nx_ctrl;
    nx_ints_d  = step ? step_ints : nx_ints;
    nx_oe_d    = nx_oe;
    nx_inte_d  = nx_inte;
    nx_ptrig_d = nx_ptrig;
    nx_aux_d   = nx_aux;
    if (wr_hit[RIDX_OUT])   nx_out_d   = bus_wdata;
    if (wr_hit[RIDX_OE])    nx_oe_d    = bus_wdata;
    if (wr_hit[RIDX_INTE])  nx_inte_d  = bus_wdata;
    if (wr_hit[RIDX_PTRIG]) nx_ptrig_d = bus_wdata;
    if (wr_hit[RIDX_AUX])   nx_aux_d   = bus_wdata;
    if (wr_hit[RIDX_CTRL])  nx_ctrl_d  = bus_wdata;
    if (wr_hit[RIDX_INTS])  nx_ints_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      nx_out <= '0; nx_oe <= '0; nx_inte <= '0; nx_ptrig <= '0;
      nx_aux <= '0; nx_ctrl <= '0; nx_ints <= '0;
    end else begin
      nx_out <= nx_out_d; nx_oe <= nx_oe_d; nx_inte <= nx_inte_d;
      nx_ptrig <= nx_ptrig_d; nx_aux <= nx_aux_d;
      nx_ctrl <= nx_ctrl_d; nx_ints <= nx_ints_d;
    end
  end

  // applied registers, enabled by the step
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cr_in <= '0; cr_out <= '0; cr_oe <= '0; cr_inte <= '0;
      cr_ptrig <= '0; cr_aux <= '0; cr_ctrl <= '0; cr_ints <= '0;
    end else if (step) begin
      cr_in    <= step_in;
      cr_out   <= step_out;
      cr_oe    <= nx_oe;
      cr_inte  <= nx_inte;
      cr_ptrig <= nx_ptrig;
      cr_aux   <= nx_aux;
      cr_ctrl  <= step_ctrl;
      cr_ints  <= step_ints;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      case (reg_idx_e'(word_idx[2:0]))
        RIDX_IN:    bus_rdata = cr_in | cr_out;
        RIDX_OUT:   bus_rdata = cr_out;
        RIDX_OE:    bus_rdata = cr_oe;
        RIDX_INTE:  bus_rdata = cr_inte;
        RIDX_PTRIG: bus_rdata = cr_ptrig;
        RIDX_AUX:   bus_rdata = cr_aux;
        RIDX_CTRL:  bus_rdata = cr_ctrl;
        RIDX_INTS:  bus_rdata = cr_ints;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = cr_out;
  assign pad_oe  = cr_oe;
  assign irq     = cr_ctrl[CTL_IFLAG];

  // R4
  out_oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pad_out & ~pad_oe) == '0);

  // R3
  in_oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cr_in & cr_oe) == '0);

  // R12
  ints_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_hit[RIDX_INTS] |=> ((nx_ints & $past(nx_ints)) == $past(nx_ints)));
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [5:0]    bus_addr;
  logic [W-1:0]  bus_wdata, bus_rdata;
  logic [W-1:0]  pad_in, pad_out, pad_oe, aux_in;
  logic          ext_clk, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .aux_in(aux_in),
    .ext_clk(ext_clk), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] oe, aux, out, auxv, pad, exp_out, exp_in;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h0000FFFF, 32'h00000000, 32'h12345678, 32'h00000000, 32'hABCD0000, 32'h00005678, 32'hABCD5678},
    '{32'hFFFFFFFF, 32'h000000FF, 32'hAAAAAAAA, 32'h0000003C, 32'hFFFFFFFF, 32'hAAAAAA3C, 32'hAAAAAA3C},
    '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h5A5A5A5A, 32'h00000000, 32'h5A5A5A5A},
    '{32'hF0F0F0F0, 32'hFF00FF00, 32'h0F0F0F0F, 32'h33333333, 32'hCCCCCCCC, 32'h30003000, 32'h3C0C3C0C}
  };

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_xclk(input logic v);
    @(negedge clk);
    ext_clk = v;
    settle(5);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary_and_end();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; aux_in = '0; ext_clk = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      bus_read(6'(i * 4), rd);
      check("R1 register", rd, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);

    // R2 readback and unmapped reads
    bus_write(6'h0C, 32'hDEADBEEF);
    bus_write(6'h10, 32'hCAFEF00D);
    settle(2);
    bus_read(6'h0C, rd); check("R2 inte readback", rd, 32'hDEADBEEF);
    bus_read(6'h10, rd); check("R2 ptrig readback", rd, 32'hCAFEF00D);
    bus_read(6'h20, rd); check("R2 unmapped", rd, 32'h0);
    bus_read(6'h06, rd); check("R2 unaligned", rd, 32'h0);
    bus_write(6'h0C, 32'h0);
    bus_write(6'h10, 32'h0);

    // R3 R4 R5 vector table
    foreach (VECS[k]) begin
      bus_write(6'h08, VECS[k].oe);
      bus_write(6'h14, VECS[k].aux);
      bus_write(6'h04, VECS[k].out);
      aux_in = VECS[k].auxv;
      pad_in = VECS[k].pad;
      settle(5);
      check("R4 R5 pad_out", pad_out, VECS[k].exp_out);
      check("R4 pad_oe", pad_oe, VECS[k].oe);
      bus_read(6'h00, rd);
      check("R3 in read", rd, VECS[k].exp_in);
    end

    // R3 writes to IN ignored
    bus_write(6'h08, 32'h0);
    bus_write(6'h14, 32'h0);
    bus_write(6'h04, 32'h0);
    aux_in = '0; pad_in = '0;
    bus_write(6'h00, 32'hFFFFFFFF);
    settle(5);
    bus_read(6'h00, rd); check("R3 in write ignored", rd, 32'h0);

    // R6 R7 deferred write in system-clock mode
    bus_write(6'h08, 32'hFFFFFFFF);
    settle(2);
    bus_write(6'h04, 32'h000000C3);
    bus_read(6'h04, rd); check("R6 write not yet applied", rd, 32'h0);
    settle(1);
    bus_read(6'h04, rd); check("R7 applied after one cycle", rd, 32'h000000C3);
    bus_write(6'h04, 32'h0);

    // R8 external rising edge
    bus_write(6'h18, 32'h4);
    settle(3);
    bus_write(6'h04, 32'h000000A5);
    settle(6);
    check("R6 R8 no step without edge", pad_out, 32'h0);
    bus_read(6'h04, rd); check("R8 out unchanged", rd, 32'h0);
    set_xclk(1'b1);
    check("R8 rising step", pad_out, 32'h000000A5);
    bus_write(6'h04, 32'h00000011);
    set_xclk(1'b0);
    check("R8 falling ignored", pad_out, 32'h000000A5);
    bus_write(6'h18, 32'hC);
    set_xclk(1'b1);
    check("R8 rising step 2", pad_out, 32'h00000011);

    // R9 external falling edge
    bus_write(6'h04, 32'h0000005A);
    set_xclk(1'b0);
    check("R9 falling step", pad_out, 32'h0000005A);
    bus_write(6'h04, 32'h00000077);
    set_xclk(1'b1);
    check("R9 rising ignored", pad_out, 32'h0000005A);
    set_xclk(1'b0);
    check("R9 falling step 2", pad_out, 32'h00000077);
    bus_write(6'h18, 32'h0);
    set_xclk(1'b1);
    set_xclk(1'b0);
    bus_read(6'h18, rd); check("R9 back to system clock", rd, 32'h0);

    // R10 R11 R12 interrupts: bits 0-3 rising, 4-7 falling, bit 7 disabled
    bus_write(6'h08, 32'h0);
    bus_write(6'h04, 32'h0);
    pad_in = 32'h000000F0;
    settle(5);
    bus_write(6'h10, 32'h0000000F);
    bus_write(6'h0C, 32'h0000007F);
    bus_write(6'h18, 32'h1);
    settle(4);
    bus_read(6'h1C, rd); check("R11 no event yet", rd, 32'h0);
    check("R12 irq idle", {31'b0, irq}, 32'h0);

    pad_in = 32'h000000F1; settle(5);
    bus_read(6'h1C, rd); check("R10 rising event", rd, 32'h00000001);
    bus_read(6'h18, rd); check("R12 flag set", rd, 32'h00000003);
    check("R12 irq high", {31'b0, irq}, 32'h1);

    pad_in = 32'h000000E1; settle(5);
    bus_read(6'h1C, rd); check("R10 falling event", rd, 32'h00000011);

    pad_in = 32'h00000061; settle(5);
    bus_read(6'h1C, rd); check("R11 bit disabled", rd, 32'h00000011);

    pad_in = 32'h00000060; settle(5);
    bus_read(6'h1C, rd); check("R10 R12 wrong polarity, sticky", rd, 32'h00000011);

    bus_write(6'h1C, 32'h0);
    bus_write(6'h18, 32'h0);
    settle(3);
    bus_read(6'h1C, rd); check("R12 status cleared", rd, 32'h0);
    check("R12 irq cleared", {31'b0, irq}, 32'h0);

    pad_in = 32'h00000062; settle(5);
    bus_read(6'h1C, rd); check("R11 global disable", rd, 32'h0);
    check("R11 irq stays low", {31'b0, irq}, 32'h0);

    summary_and_end();
  end
endmodule